// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counting Timer

This block is a bank of down-counting timers that share one clock divider. The divider counts down once per clock. When it is decremented from zero it takes its reload value again and sends a one-cycle tick to all channels. Each enabled channel counts down by one on every tick.

When a channel is decremented from zero it underflows. Depending on its control word it then either restarts from its own reload value or stops at zero and switches itself off. Each channel can raise a one-cycle interrupt pulse on underflow. Software can also copy a channel's reload value into its counter at any moment.

Software reaches the block through a simple 32-bit register port. Writes take effect on the clock edge. Reads are combinational from a byte address whose two low bits are ignored.

Top module: `ptimer_unit`

## Requirements
- R1: After reset, every readable register reads 0 except the status word, and every `irq` bit is low.
- R2: The divider value falls by one on each clock. When it is 0 at a clock edge it takes the divider reload value instead and ticks the channels in that same cycle, so a reload of N gives one tick every N+1 cycles.
- R3: A channel with enable (control bit 0) clear holds its counter through ticks.
- R4: An enabled channel whose counter is 0 on a tick, with reload-select (control bit 1) set, takes its reload value and keeps counting.
- R5: An enabled channel whose counter is 0 on a tick, with reload-select clear, stays at 0 and clears its own enable bit.
- R6: Writing a control word with bit 2 set copies the channel's reload value into its counter. Bit 2 always reads back 0, and writing it as 0 leaves the counter unchanged.
- R7: On an underflow, `irq[n]` is high for exactly one cycle, starting at the edge of the underflow, and only if interrupt-enable (control bit 3) was set. No pulse is raised without a tick.
- R8: The word at 0x08 is read-only and returns the number of channels in bits 2:0, with the other bits 0.
- R9: The address map is as follows. 0x00 is the divider value, 0x04 the divider reload, 0x08 the status word, and 0x0C reads 0. Channel n sits at 0x10+0x10·n, with its counter at +0, its reload at +4, its control word at +8 and zero at +0xC. Addresses of channels that are not built read 0.
- R10: A write to a counter or to the divider value replaces it on that edge. Such a write, or a load command, takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | NUM_TMR | Per-channel underflow pulse |

## Verification
A wrong divider count moves every channel's tick. It shows in the divider readback on the next cycle and in all counters within one divider period. A wrong counter or control state in a channel shows on the next read of that channel. A missing stop-clear or reload shows within one tick after the underflow. A spurious or missing interrupt shows at the same edge as the faulty underflow. The bench model is compared on every clock against the interrupt lines and against a sweep of read addresses, so a divergence is caught within one sweep.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
    localparam int CTL_EN = 0;
    localparam int CTL_RL = 1;
    localparam int CTL_LD = 2;
    localparam int CTL_IE = 3;

    typedef struct packed {
        logic ie;
        logic rl;
        logic en;
    } chan_ctl_t;
endpackage

// File: rtl/ptu_prescaler.sv
module ptu_prescaler #(
    parameter int SCL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic             wr_rld,
    input  logic [SCL_W-1:0] wdata,
    output logic [SCL_W-1:0] val,
    output logic [SCL_W-1:0] rld,
    output logic             tick
);
    typedef struct packed {
        logic [SCL_W-1:0] val;
        logic [SCL_W-1:0] rld;
    } scl_st_t;

    scl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.val == '0);
        if (wr_val)    st_d.val = wdata;
        else if (tick) st_d.val = st_q.rld;
        else           st_d.val = st_q.val - 1'b1;
        if (wr_rld)    st_d.rld = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;
    assign rld = st_q.rld;

    // R2: the value taken on a tick is the reload held before the edge
    assert_reload_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_val) |=> (val == $past(rld)));
    // R2: the value steps down by one between ticks
    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_val) |=> (val == $past(val) - 1'b1));
endmodule

// File: rtl/ptu_channel.sv
module ptu_channel
    import ptu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_val,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rld,
    output chan_ctl_t        ctl,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        chan_ctl_t        ctl;
        logic             irq;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_val) begin
            st_d.cnt = wdata[CNT_W-1:0];
        end else if (wr_ctl && wdata[CTL_LD]) begin
            st_d.cnt = st_q.rld;
        end else if (tick && st_q.ctl.en) begin
            if (st_q.cnt == '0) begin
                st_d.irq = st_q.ctl.ie;
                if (st_q.ctl.rl) st_d.cnt    = st_q.rld;
                else             st_d.ctl.en = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (wr_rld) st_d.rld = wdata[CNT_W-1:0];
        if (wr_ctl) begin
            st_d.ctl.en = wdata[CTL_EN];
            st_d.ctl.rl = wdata[CTL_RL];
            st_d.ctl.ie = wdata[CTL_IE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign rld = st_q.rld;
    assign ctl = st_q.ctl;
    assign irq = st_q.irq;

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.en && !wr_val && !wr_ctl) |=> $stable(cnt));
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctl.en && cnt == '0 && ctl.rl && !wr_val && !wr_ctl) |=> (cnt == $past(rld)));
    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctl.en && cnt == '0 && !ctl.rl && !wr_val && !wr_ctl) |=> (cnt == '0 && !ctl.en));
    assert_irq_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq || $past(tick));
endmodule

// File: rtl/ptimer_unit.sv
module ptimer_unit
    import ptu_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32,
    parameter int SCL_W   = 16,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_TMR-1:0] irq
);
    localparam int SLOT_W = 4;
    localparam int REG_W  = 2;

    logic [SLOT_W-1:0] slot;
    logic [REG_W-1:0]  rsel;
    logic              tick;
    logic [SCL_W-1:0]  scl_val, scl_rld;

    logic [CNT_W-1:0]  cnt_a [NUM_TMR];
    logic [CNT_W-1:0]  rld_a [NUM_TMR];
    chan_ctl_t         ctl_a [NUM_TMR];

    assign slot = bus_addr[7:4];
    assign rsel = bus_addr[3:2];

    ptu_prescaler #(.SCL_W(SCL_W)) u_scl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_val (bus_wr && slot == '0 && rsel == 2'd0),
        .wr_rld (bus_wr && slot == '0 && rsel == 2'd1),
        .wdata  (bus_wdata[SCL_W-1:0]),
        .val    (scl_val),
        .rld    (scl_rld),
        .tick   (tick)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(g + 1);
        ptu_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .wr_val (bus_wr && slot == MY_SLOT && rsel == 2'd0),
            .wr_rld (bus_wr && slot == MY_SLOT && rsel == 2'd1),
            .wr_ctl (bus_wr && slot == MY_SLOT && rsel == 2'd2),
            .wdata  (bus_wdata),
            .cnt    (cnt_a[g]),
            .rld    (rld_a[g]),
            .ctl    (ctl_a[g]),
            .irq    (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (slot == '0) begin
            case (rsel)
                2'd0:    bus_rdata = 32'(scl_val);
                2'd1:    bus_rdata = 32'(scl_rld);
                2'd2:    bus_rdata = 32'(NUM_TMR);
                default: bus_rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (slot == SLOT_W'(i + 1)) begin
                case (rsel)
                    2'd0:    bus_rdata = 32'(cnt_a[i]);
                    2'd1:    bus_rdata = 32'(rld_a[i]);
                    2'd2:    bus_rdata = {28'd0, ctl_a[i].ie, 1'b0, ctl_a[i].rl, ctl_a[i].en};
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/ptimer_unit_bench.sv
module ptimer_unit_bench;
    localparam int NT = 4;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire  [NT-1:0] irq;

    int errs = 0, checks = 0;
    int irq_seen [NT];

    logic [31:0] m_scl, m_srl;
    logic [31:0] m_cnt [NT];
    logic [31:0] m_rld [NT];
    logic        m_en [NT], m_rl [NT], m_ie [NT], m_irq [NT];

    always #2 clk = ~clk;

    ptimer_unit #(.NUM_TMR(NT)) u_ptimer_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(logic [7:0] a);
        int s = int'(a[7:4]);
        int r = int'(a[3:2]);
        if (s == 0) begin
            if (r == 0) return m_scl;
            if (r == 1) return m_srl;
            if (r == 2) return 32'(NT);
            return 0;
        end
        if (s <= NT) begin
            if (r == 0) return m_cnt[s-1];
            if (r == 1) return m_rld[s-1];
            if (r == 2) return {28'd0, m_ie[s-1], 1'b0, m_rl[s-1], m_en[s-1]};
        end
        return 0;
    endfunction

    always @(posedge clk) begin : ref_model
        logic tk;
        int b;
        if (!rst_n) begin
            m_scl = 0; m_srl = 0;
            for (int i = 0; i < NT; i++) begin
                m_cnt[i] = 0; m_rld[i] = 0; m_en[i] = 0; m_rl[i] = 0; m_ie[i] = 0; m_irq[i] = 0;
            end
        end else begin
            tk = (m_scl == 0);
            for (int i = 0; i < NT; i++) begin
                b = 16 + 16 * i;
                m_irq[i] = 0;
                if (bus_wr && bus_addr == 8'(b)) m_cnt[i] = bus_wdata;
                else if (bus_wr && bus_addr == 8'(b + 8) && bus_wdata[2]) m_cnt[i] = m_rld[i];
                else if (tk && m_en[i]) begin
                    if (m_cnt[i] == 0) begin
                        m_irq[i] = m_ie[i];
                        if (m_rl[i]) m_cnt[i] = m_rld[i];
                        else m_en[i] = 0;
                    end else m_cnt[i] = m_cnt[i] - 1;
                end
                if (bus_wr && bus_addr == 8'(b + 4)) m_rld[i] = bus_wdata;
                if (bus_wr && bus_addr == 8'(b + 8)) begin
                    m_en[i] = bus_wdata[0]; m_rl[i] = bus_wdata[1]; m_ie[i] = bus_wdata[3];
                end
            end
            if (bus_wr && bus_addr == 8'h00) m_scl = bus_wdata & 32'hFFFF;
            else if (tk) m_scl = m_srl;
            else m_scl = m_scl - 1;
            if (bus_wr && bus_addr == 8'h04) m_srl = bus_wdata & 32'hFFFF;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NT; i++) begin
                chk("R7 irq vs model", 32'(irq[i]), 32'(m_irq[i]));
                if (irq[i]) irq_seen[i]++;
            end
            chk("R9 readback vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1 bus_addr = a;
        @(negedge clk); chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(4 * 200000);
        errs++; checks++;
        $display("FAIL watchdog all-reqs act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) irq_seen[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 0, "R1 divider");
        rd(8'h10, 0, "R1 ch0 count");
        rd(8'h28, 0, "R1 ch1 control");
        chk("R1 irq low", 32'(irq), 0);
        // R8 status
        rd(8'h08, NT, "R8 status");
        wr(8'h08, 32'hFF);
        rd(8'h08, NT, "R8 status after write");
        rd(8'h0C, 0, "R9 unused word");
        rd(8'h50, 0, "R9 absent channel");
        // R10 divider write
        wr(8'h04, 3);
        wr(8'h00, 3);
        rd(8'h00, 2, "R10 divider write then step R2");
        // channel setup
        wr(8'h14, 5);  wr(8'h18, 32'hF);
        wr(8'h24, 2);  wr(8'h28, 32'hD);
        wr(8'h34, 7);  wr(8'h38, 32'h7);
        wr(8'h40, 9);
        rd(8'h18, 32'hB, "R6 load bit reads 0");
        rd(8'h40, 9, "R10 counter write");
        for (int k = 0; k < 160; k++) begin
            @(posedge clk); #1 bus_addr = 8'(4 * (k % 22));
        end
        rd(8'h28, 32'h8, "R5 enable cleared");
        rd(8'h20, 0, "R5 held at zero");
        chk("R7 no pulse without enable", irq_seen[2], 0);
        chk("R7 one pulse for stopped channel", irq_seen[1], 1);
        chk("R4 restarting channel pulsed", 32'(irq_seen[0] > 1), 1);
        rd(8'h40, 9, "R3 disabled holds");
        wr(8'h48, 0);
        rd(8'h40, 9, "R6 load bit 0 no effect");
        wr(8'h44, 32'h55);
        wr(8'h48, 32'h4);
        rd(8'h40, 32'h55, "R6 load copies reload");
        rd(8'h48, 0, "R6 control after load");
        // R2 divider reload 0: tick every cycle
        wr(8'h04, 0);
        wr(8'h00, 0);
        wr(8'h48, 32'h3);
        rd(8'h40, 32'h54, "R2 tick every cycle");
        rd(8'h40, 32'h53, "R2 tick every cycle next");
        // R4 restart on underflow with pulse
        wr(8'h10, 0);
        rd(8'h10, 5, "R4 restart from reload");
        chk("R7 pulse at restart", 32'(irq[0]), 1);
        rd(8'h10, 4, "R4 counting after restart");
        chk("R7 pulse one cycle", 32'(irq[0]), 0);
        repeat (40) @(posedge clk);
        summary();
        $finish;
    end
endmodule